// File: doc/BRIEF.md
# PWM Shadow Register Reload Controller

This block holds the double-buffered configuration of one PWM channel group. Software writes a staging copy of six compare values, a counter start value, a fractional value and a 3-bit prescaler select over a small register bus. It then arms a transfer by setting a load flag. The transfer copies all staged values into the working registers that drive the PWM counter logic.

In reload mode the copy waits for the counter's reload pulse. In immediate mode it happens on the clock edge after the flag is set. While the flag is armed the staging registers are frozen. A cancel command disarms the flag before any copy happens. A cancel that meets a reload pulse in the same cycle wins, and the working set keeps its old contents.

Top module: `pwm_shadow_reload`

Register offsets, with the defaults: 0 to 5 hold the staged compare values, 6 the start value, 7 the fractional value and 8 the prescaler (bits 2:0). Offset 9 is the mode register: bit 0 at 1 selects immediate mode. Offset 10 is the load register: bit 0 arms and bit 1 cancels. Offsets 16 to 24 read back the working copies in the same slot order.

## Requirements
- R1: After reset the load flag is 0, immediate mode is off, and every staged and working value reads 0.
- R2: Writing the load register with bit 0 at 1 sets the load flag. Writing it with bit 0 at 0 leaves the flag unchanged. Only reset and the conditions in R4, R5, R7 and R8 clear the flag.
- R3: While the load flag is 1, bus writes to the staged slots (offsets 0 to 8) leave them unchanged.
- R4: In reload mode with the flag at 1, a reload pulse without a cancel copies all staged slots into the working slots at that clock edge. The flag clears on the same edge, and `xfer_o` is 1 during that cycle.
- R5: In immediate mode, the copy happens on the first clock edge after the flag becomes 1, whether or not a reload pulse is present. The flag clears on that edge.
- R6: A reload pulse while the flag is 0 leaves every working slot unchanged.
- R7: Writing the load register with bit 1 at 1 clears the flag on the next edge. A later reload pulse then performs no copy.
- R8: A cancel write in the same cycle as a reload pulse, with the flag at 1, performs no copy and clears the flag.
- R9: The prescaler slot keeps only its low 3 bits. Bit 1 of the load register always reads 0, and bit 0 of that register reads the flag.
- R10: Offsets 16 upward read the working slots in staged-slot order, and the working values also appear on dedicated output ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| reload_i | input | 1 | Reload pulse from the PWM counter |
| armed_o | output | 1 | Load flag state |
| xfer_o | output | 1 | High in the cycle whose edge performs a copy |
| cmp_work_o | output | 96 | Working compare values, slot 0 in the low 16 bits |
| init_work_o | output | 16 | Working counter start value |
| frac_work_o | output | 16 | Working fractional value |
| prsc_work_o | output | 3 | Working prescaler select |

## Verification
Two events can meet in one cycle: a cancel write to the load register and the counter's reload pulse. The bench arms the flag with new values staged, then raises the reload pulse in the same cycle as a write that sets the cancel bit. It judges the result on three points: `xfer_o` stays 0 in that cycle, the flag reads 0 afterwards, and the working compare value still holds the earlier copy. A separate run cancels well before a reload, and another shows that immediate mode ignores the reload pulse.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
    // bit positions inside the load and mode registers
    localparam int LD_ARM_BIT    = 0;
    localparam int LD_CANCEL_BIT = 1;
    localparam int MODE_IMM_BIT  = 0;

    // decoded control command for the flag logic
    typedef struct packed {
        logic arm;
        logic cancel;
        logic mode_we;
        logic mode_val;
    } ctl_cmd_t;
endpackage

// File: rtl/pwm_shadow_stage.sv
module pwm_shadow_stage #(
    parameter int NSLOT    = 9,
    parameter int DW       = 16,
    parameter int PRSC_W   = 3,
    parameter int PRSC_IDX = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NSLOT-1:0]           slot_we,
    input  logic [DW-1:0]              wdata,
    input  logic                       lock_i,
    output logic [NSLOT-1:0][DW-1:0]   stage_o
);
    localparam logic [DW-1:0] PMASK = {{(DW-PRSC_W){1'b0}}, {PRSC_W{1'b1}}};

    typedef struct packed {
        logic [NSLOT-1:0][DW-1:0] word;
    } stage_t;

    stage_t s_d, s_q;
    logic [NSLOT-1:0][DW-1:0] slot_mask;

    for (genvar g = 0; g < NSLOT; g++) begin : g_mask
        if (g == PRSC_IDX) begin : g_prsc
            assign slot_mask[g] = PMASK;
        end else begin : g_full
            assign slot_mask[g] = '1;
        end
    end

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NSLOT; i++) begin
            if (slot_we[i] && !lock_i) begin
                s_d.word[i] = wdata & slot_mask[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stage_o = s_q.word;

    // R3
    stage_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> $stable(s_q));

    // R9
    prsc_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.word[PRSC_IDX] & ~PMASK) == '0);
endmodule

// File: rtl/pwm_shadow_arm.sv
module pwm_shadow_arm
    import pwm_shadow_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ctl_cmd_t cmd_i,
    input  logic     reload_i,
    output logic     armed_o,
    output logic     imm_o,
    output logic     xfer_o
);
    typedef struct packed {
        logic ldok;
        logic imm;
    } arm_t;

    arm_t a_d, a_q;
    logic xfer;

    always_comb begin
        a_d  = a_q;
        xfer = a_q.ldok && !cmd_i.cancel && (a_q.imm || reload_i);
        if (cmd_i.mode_we) a_d.imm = cmd_i.mode_val;
        if (cmd_i.cancel)      a_d.ldok = 1'b0;
        else if (xfer)         a_d.ldok = 1'b0;
        else if (cmd_i.arm)    a_d.ldok = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign armed_o = a_q.ldok;
    assign imm_o   = a_q.imm;
    assign xfer_o  = xfer;

    // R4
    xfer_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o |=> !armed_o);

    // R7
    cancel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.cancel |=> !armed_o);

    // R8
    cancel_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.cancel |-> !xfer_o);

    // R2
    no_spurious_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_o && !cmd_i.arm) |=> !armed_o);

    // R5
    imm_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && imm_o && !cmd_i.cancel) |-> xfer_o);
endmodule

// File: rtl/pwm_shadow_work.sv
module pwm_shadow_work #(
    parameter int NSLOT = 9,
    parameter int DW    = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      xfer_i,
    input  logic [NSLOT-1:0][DW-1:0]  stage_i,
    output logic [NSLOT-1:0][DW-1:0]  work_o
);
    typedef struct packed {
        logic [NSLOT-1:0][DW-1:0] word;
    } work_t;

    work_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (xfer_i) w_d.word = stage_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign work_o = w_q.word;

    // R6
    work_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_i |=> $stable(w_q));

    // R4
    work_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_i |=> (w_q.word == $past(stage_i)));
endmodule

// File: rtl/pwm_shadow_reload.sv
module pwm_shadow_reload
    import pwm_shadow_pkg::*;
#(
    parameter int NUM_CMP = 6,
    parameter int DATA_W  = 16,
    parameter int PRSC_W  = 3,
    parameter int ADDR_W  = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    input  logic                      bus_we,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic                      reload_i,
    output logic                      armed_o,
    output logic                      xfer_o,
    output logic [NUM_CMP*DATA_W-1:0] cmp_work_o,
    output logic [DATA_W-1:0]         init_work_o,
    output logic [DATA_W-1:0]         frac_work_o,
    output logic [PRSC_W-1:0]         prsc_work_o
);
    localparam int NSLOT     = NUM_CMP + 3;
    localparam int INIT_IDX  = NUM_CMP;
    localparam int FRAC_IDX  = NUM_CMP + 1;
    localparam int PRSC_IDX  = NUM_CMP + 2;
    localparam int WORK_BASE = 2 ** (ADDR_W - 1);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(NSLOT);
    localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(NSLOT + 1);

    logic [NSLOT-1:0]              slot_we;
    logic [NSLOT-1:0][DATA_W-1:0]  stage;
    logic [NSLOT-1:0][DATA_W-1:0]  work;
    ctl_cmd_t                      cmd;
    logic                          armed;
    logic                          imm;
    logic                          xfer;

    for (genvar g = 0; g < NSLOT; g++) begin : g_dec
        assign slot_we[g] = bus_we && (bus_addr == ADDR_W'(g));
    end

    always_comb begin
        cmd          = '0;
        cmd.mode_we  = bus_we && (bus_addr == A_MODE);
        cmd.mode_val = bus_wdata[MODE_IMM_BIT];
        cmd.arm      = bus_we && (bus_addr == A_LOAD) && bus_wdata[LD_ARM_BIT];
        cmd.cancel   = bus_we && (bus_addr == A_LOAD) && bus_wdata[LD_CANCEL_BIT];
    end

    pwm_shadow_stage #(
        .NSLOT(NSLOT), .DW(DATA_W), .PRSC_W(PRSC_W), .PRSC_IDX(PRSC_IDX)
    ) u_stage (
        .clk(clk), .rst_n(rst_n), .slot_we(slot_we), .wdata(bus_wdata),
        .lock_i(armed), .stage_o(stage)
    );

    pwm_shadow_arm u_arm (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .reload_i(reload_i),
        .armed_o(armed), .imm_o(imm), .xfer_o(xfer)
    );

    pwm_shadow_work #(
        .NSLOT(NSLOT), .DW(DATA_W)
    ) u_work (
        .clk(clk), .rst_n(rst_n), .xfer_i(xfer), .stage_i(stage), .work_o(work)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (bus_addr == ADDR_W'(i))             bus_rdata = stage[i];
            if (bus_addr == ADDR_W'(WORK_BASE + i)) bus_rdata = work[i];
        end
        if (bus_addr == A_MODE) bus_rdata[MODE_IMM_BIT] = imm;
        if (bus_addr == A_LOAD) bus_rdata[LD_ARM_BIT]   = armed;
    end

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        assign cmp_work_o[g*DATA_W +: DATA_W] = work[g];
    end

    assign init_work_o = work[INIT_IDX];
    assign frac_work_o = work[FRAC_IDX];
    assign prsc_work_o = work[PRSC_IDX][PRSC_W-1:0];
    assign armed_o     = armed;
    assign xfer_o      = xfer;
endmodule

// File: tb/pwm_shadow_reload_bench.sv
module pwm_shadow_reload_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_rdata;
    logic        reload_i = 1'b0;
    logic        armed_o, xfer_o;
    logic [95:0] cmp_work_o;
    logic [15:0] init_work_o, frac_work_o;
    logic [2:0]  prsc_work_o;

    localparam int K_ARM = 0, K_WORK = 1, K_RD = 2, K_XFER = 3;
    localparam logic [4:0] A_INIT = 5'd6, A_FRAC = 5'd7, A_PRSC = 5'd8;
    localparam logic [4:0] A_MODE = 5'd9, A_LOAD = 5'd10, A_WORK = 5'd16;

    typedef struct {
        int          kind;
        int          idx;
        logic [15:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sbq[$];
    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    pwm_shadow_reload u_pwm_shadow_reload (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .reload_i(reload_i),
        .armed_o(armed_o), .xfer_o(xfer_o), .cmp_work_o(cmp_work_o),
        .init_work_o(init_work_o), .frac_work_o(frac_work_o),
        .prsc_work_o(prsc_work_o)
    );

    function automatic logic [15:0] work_word(input int idx);
        if (idx < 6)  return cmp_work_o[idx*16 +: 16];
        if (idx == 6) return init_work_o;
        if (idx == 7) return frac_work_o;
        return {13'd0, prsc_work_o};
    endfunction

    // monitor: pops expected items and compares against the ports
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            sb_item_t it;
            logic [15:0] act;
            it = sbq.pop_front();
            case (it.kind)
                K_ARM:   act = {15'd0, armed_o};
                K_XFER:  act = {15'd0, xfer_o};
                K_WORK:  act = work_word(it.idx);
                default: act = bus_rdata;
            endcase
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                         it.tag, it.kind, it.idx, act, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic push(input int kind, input int idx, input logic [15:0] exp, input string tag);
        sb_item_t it;
        it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [15:0] exp, input string tag);
        bus_addr = a;
        push(K_RD, 0, exp, tag);
        settle();
    endtask

    task automatic stage_all(input logic [15:0] base);
        for (int i = 0; i < 6; i++) wr(5'(i), base + 16'(i));
        wr(A_INIT, base + 16'h40);
        wr(A_FRAC, base + 16'h0ABC);
        wr(A_PRSC, 16'hFFF5);
    endtask

    task automatic reload_pulse(input logic exp_xfer, input string tag);
        @(posedge clk); #1;
        reload_i = 1'b1;
        push(K_XFER, 0, {15'd0, exp_xfer}, tag);
        settle();
        @(posedge clk); #1;
        reload_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        settle();

        // R1 reset state
        push(K_ARM, 0, 16'h0, "R1");
        for (int i = 0; i < 9; i++) push(K_WORK, i, 16'h0, "R1");
        settle();
        rd_chk(5'd2, 16'h0, "R1");
        rd_chk(A_MODE, 16'h0, "R1");

        // staging and prescaler width, R9
        stage_all(16'h1100);
        rd_chk(A_PRSC, 16'h0005, "R9");
        rd_chk(5'd3, 16'h1103, "R10");

        // R6 reload with flag clear
        reload_pulse(1'b0, "R6");
        push(K_WORK, 0, 16'h0, "R6");
        push(K_WORK, 7, 16'h0, "R6");
        settle();

        // R2 zero write has no effect, one sets
        wr(A_LOAD, 16'h0000);
        push(K_ARM, 0, 16'h0, "R2");
        settle();
        wr(A_LOAD, 16'h0001);
        push(K_ARM, 0, 16'h1, "R2");
        settle();
        rd_chk(A_LOAD, 16'h0001, "R9");

        // R3 staged writes locked while armed
        wr(5'd0, 16'hDEAD);
        wr(A_INIT, 16'hBEEF);
        rd_chk(5'd0, 16'h1100, "R3");
        rd_chk(A_INIT, 16'h1140, "R3");
        wr(A_LOAD, 16'h0000);
        push(K_ARM, 0, 16'h1, "R2");
        settle();

        // R4 reload-mode copy
        reload_pulse(1'b1, "R4");
        push(K_ARM, 0, 16'h0, "R4");
        push(K_WORK, 0, 16'h1100, "R4");
        push(K_WORK, 5, 16'h1105, "R4");
        push(K_WORK, 6, 16'h1140, "R4");
        push(K_WORK, 7, 16'h1BBC, "R4");
        push(K_WORK, 8, 16'h0005, "R4");
        settle();
        rd_chk(A_WORK, 16'h1100, "R10");
        rd_chk(A_WORK + 5'd8, 16'h0005, "R10");

        // R7 cancel before reload
        stage_all(16'h2200);
        wr(A_LOAD, 16'h0001);
        push(K_ARM, 0, 16'h1, "R7");
        settle();
        wr(A_LOAD, 16'h0002);
        push(K_ARM, 0, 16'h0, "R7");
        settle();
        reload_pulse(1'b0, "R7");
        push(K_WORK, 0, 16'h1100, "R7");
        settle();

        // R8 cancel in the same cycle as reload
        wr(A_LOAD, 16'h0001);
        push(K_ARM, 0, 16'h1, "R8");
        settle();
        @(posedge clk); #1;
        bus_addr = A_LOAD; bus_wdata = 16'h0002; bus_we = 1'b1; reload_i = 1'b1;
        push(K_XFER, 0, 16'h0, "R8");
        settle();
        @(posedge clk); #1;
        bus_we = 1'b0; reload_i = 1'b0;
        push(K_ARM, 0, 16'h0, "R8");
        push(K_WORK, 0, 16'h1100, "R8");
        push(K_WORK, 6, 16'h1140, "R8");
        settle();

        // R5 immediate mode
        wr(A_MODE, 16'h0001);
        rd_chk(A_MODE, 16'h0001, "R5");
        wr(A_LOAD, 16'h0001);
        push(K_ARM, 0, 16'h1, "R5");
        push(K_XFER, 0, 16'h1, "R5");
        push(K_WORK, 0, 16'h1100, "R5");
        settle();
        @(posedge clk); #1;
        push(K_ARM, 0, 16'h0, "R5");
        push(K_WORK, 0, 16'h2200, "R5");
        push(K_WORK, 7, 16'h2CBC, "R5");
        settle();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule